// File: doc/BRIEF.md
# NAND address cycle sequencer

This block turns a column address and a page address into the series of byte-wide address cycles that a NAND device expects after a command. A request gives a presence flag for each address, the page address, a page-size flag (set when pages are larger than 512 bytes) and the device capacity as a power of two in bytes. The block works out how many column and page cycles the device needs and hands them one at a time to a downstream cycle issuer.

Column cycles always carry the value zero: the controller transfers whole pages, so the column offset is applied later in the page buffer. Page bytes go out least significant first. A third page byte is added only above a capacity threshold, and that threshold is different for small-page and large-page devices. One cycle of the sequence carries a tag that tells the issuer to wait for the device after that cycle.

The output stream uses valid/ready. A cycle is transferred on a clock edge where `cyc_valid` and `cyc_ready` are both high. The issuer may hold `cyc_ready` low for as long as it likes. While it does, the byte and the tag stay frozen. `start` is a plain pulse and is taken only while the block is idle.

Top module: `nand_addr_seq`

## Requirements
- R1: With `col_present`=1 the sequence begins with one column cycle of value 0x00. A second 0x00 column cycle follows it when `big_page`=1.
- R2: The page address is sent least significant byte first: bits [7:0], then bits [15:8], then (when a third byte is due) bits [23:16].
- R3: With `big_page`=1 the third page byte is sent only when `cap_log2` >= 28 (capacity of 256 MiB or more).
- R4: With `big_page`=0 the third page byte is sent only when `cap_log2` >= 26 (capacity of 64 MiB or more).
- R5: With `page_present`=0 no page cycles are emitted.
- R6: `cyc_last`=1 marks the final page cycle when a page address is present. When the page address is absent, it marks the first column cycle instead. With `big_page`=1 this means a second, untagged zero cycle still follows the tagged one.
- R7: A cycle transfers only when `cyc_valid` and `cyc_ready` are both high. While `cyc_valid`=1 and `cyc_ready`=0, `cyc_valid`, `cyc_byte` and `cyc_last` hold their values.
- R8: `start` is taken when `busy`=0, and `busy` goes high in the next cycle. `busy` falls after the final cycle of the sequence is transferred, and at that same edge `done` pulses high for one cycle. A `start` asserted while `busy`=1 is ignored.
- R9: A `start` with both addresses absent emits no cycle. `done` pulses in the next cycle and `busy` stays low.
- R10: After reset `busy`, `cyc_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| col_present | input | 1 | Column address present |
| page_present | input | 1 | Page address present |
| page_addr | input | 24 | Page address |
| big_page | input | 1 | Page larger than 512 bytes |
| cap_log2 | input | 6 | Device capacity, log2 of bytes |
| cyc_valid | output | 1 | Address cycle available |
| cyc_ready | input | 1 | Issuer accepts the cycle |
| cyc_byte | output | 8 | Address cycle value |
| cyc_last | output | 1 | Tag: wait for device after this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at completion |

## Verification
The hardest situation to reach from the ports is a `start` arriving during back-pressure. The block is then still busy with a sequence, and the new request must not disturb the latched address. The directed sequence task can assert `start` with a different page address while it stalls `cyc_ready` on alternate cycles. The bytes collected must still match the first request, and no second sequence may follow `done`. A column-only request on a large-page device is the other subtle case: the tag lands on the first of two cycles, and only the count of transferred cycles shows that the second one still goes out.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int PG_BYTES = 3;
  localparam int COL_MAX  = 2;
  localparam int PG_W     = 8 * PG_BYTES;
  localparam int MAX_CYC  = COL_MAX + PG_BYTES;
  localparam int IDX_W    = $clog2(MAX_CYC + 1);

  typedef struct packed {
    logic            col;
    logic            pg;
    logic            wide;
    logic            full;   // all PG_BYTES page bytes are due
    logic [PG_W-1:0] addr;
  } seq_req_t;
endpackage

// File: rtl/nas_plan.sv
module nas_plan
  import nand_seq_pkg::*;
(
  input  seq_req_t         req,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] n_cyc,
  output logic [7:0]       byte_o,
  output logic             tag_o
);
  logic [IDX_W-1:0] n_col, n_pg, pg_idx;
  logic [7:0]       pg_byte [PG_BYTES];

  for (genvar g = 0; g < PG_BYTES; g++) begin : g_slice
    assign pg_byte[g] = req.addr[8*g +: 8];
  end

  always_comb begin
    n_col  = req.col ? (req.wide ? IDX_W'(COL_MAX) : IDX_W'(1)) : '0;
    n_pg   = req.pg ? (req.full ? IDX_W'(PG_BYTES) : IDX_W'(PG_BYTES - 1)) : '0;
    n_cyc  = n_col + n_pg;
    pg_idx = idx - n_col;
    byte_o = 8'h00;
    if (idx >= n_col) begin
      for (int k = 0; k < PG_BYTES; k++)
        if (pg_idx == IDX_W'(k)) byte_o = pg_byte[k];
    end
    tag_o = req.pg ? (idx == n_cyc - IDX_W'(1)) : (idx == '0);
  end
endmodule

// File: rtl/nas_emit.sv
module nas_emit
  import nand_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             launch_empty,
  input  logic [IDX_W-1:0] n_cyc,
  input  logic             ready,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (launch_empty) begin
        done <= 1'b1;
      end else if (busy && ready) begin
        if (idx == n_cyc - IDX_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nand_seq_pkg::*;
#(
  parameter int CAP_W       = 6,
  parameter int BIG_CAP_LOG2 = 28,
  parameter int SML_CAP_LOG2 = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              col_present,
  input  logic              page_present,
  input  logic [PG_W-1:0]   page_addr,
  input  logic              big_page,
  input  logic [CAP_W-1:0]  cap_log2,
  output logic              cyc_valid,
  input  logic              cyc_ready,
  output logic [7:0]        cyc_byte,
  output logic              cyc_last,
  output logic              busy,
  output logic              done
);
  seq_req_t         req_q;
  logic             take, empty, need_full;
  logic [IDX_W-1:0] idx, n_cyc;

  assign take      = start && !busy;
  assign empty     = !col_present && !page_present;
  assign need_full = big_page ? (cap_log2 >= CAP_W'(BIG_CAP_LOG2))
                              : (cap_log2 >= CAP_W'(SML_CAP_LOG2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else if (take && !empty)
      req_q <= '{col: col_present, pg: page_present, wide: big_page,
                 full: need_full, addr: page_addr};
  end

  nas_plan u_plan (
    .req(req_q), .idx(idx), .n_cyc(n_cyc), .byte_o(cyc_byte), .tag_o(cyc_last)
  );

  nas_emit u_emit (
    .clk(clk), .rst_n(rst_n), .launch(take && !empty),
    .launch_empty(take && empty), .n_cyc(n_cyc), .ready(cyc_ready),
    .busy(busy), .idx(idx), .done(done)
  );

  assign cyc_valid = busy;
endmodule

// File: rtl/nas_chk.sv
module nas_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       col_present,
  input logic       page_present,
  input logic       cyc_valid,
  input logic       cyc_ready,
  input logic [7:0] cyc_byte,
  input logic       cyc_last,
  input logic       busy,
  input logic       done
);
  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !cyc_ready |=> cyc_valid && $stable(cyc_byte) && $stable(cyc_last));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(cyc_valid && cyc_ready) |=> busy);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !col_present && !page_present |=> done && !busy);
  // R1
  col_zero_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && col_present |=> cyc_valid && cyc_byte == 8'h00);
  // R10
  always @(posedge clk) if (!rst_n) reset_state_chk: assert (!done);
endmodule

bind nand_addr_seq nas_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .col_present(col_present),
  .page_present(page_present), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
  .cyc_byte(cyc_byte), .cyc_last(cyc_last), .busy(busy), .done(done)
);

// File: tb/nand_addr_seq_tb.sv
`timescale 1ns/1ps
module nand_addr_seq_tb;
  logic        clk = 0, rst_n = 0, start = 0;
  logic        col_present = 0, page_present = 0, big_page = 0, cyc_ready = 0;
  logic [23:0] page_addr = '0;
  logic [5:0]  cap_log2 = '0;
  logic        cyc_valid, cyc_last, busy, done;
  logic [7:0]  cyc_byte;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nand_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .col_present(col_present),
    .page_present(page_present), .page_addr(page_addr), .big_page(big_page),
    .cap_log2(cap_log2), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
    .cyc_byte(cyc_byte), .cyc_last(cyc_last), .busy(busy), .done(done)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // stall: 0 always ready, 1 alternate, 2 low for the first three cycles
  task automatic run_seq(string tag, bit col, bit pg, logic [23:0] addr,
                         bit wide, int cap, int stall, bit poke);
    logic [7:0] eb [8];
    bit         el [8];
    logic [7:0] gb [8];
    bit         gl [8];
    int n = 0, got = 0, cyc = 0;
    bit prev_stall = 0;
    logic [7:0] pb = 0;
    bit pl = 0;
    int npg;
    if (col) begin
      eb[n] = 8'h00; el[n] = !pg; n++;
      if (wide) begin eb[n] = 8'h00; el[n] = 0; n++; end
    end
    npg = !pg ? 0 : ((wide ? cap >= 28 : cap >= 26) ? 3 : 2);
    for (int k = 0; k < npg; k++) begin
      eb[n] = addr[8*k +: 8]; el[n] = (k == npg - 1); n++;
    end
    @(negedge clk);
    col_present = col; page_present = pg; page_addr = addr;
    big_page = wide; cap_log2 = 6'(cap); start = 1;
    @(negedge clk);
    start = 0;
    if (n == 0) begin
      chk({tag, " R9 done"}, done, 1);
      chk({tag, " R9 busy"}, busy, 0);
      chk({tag, " R9 valid"}, cyc_valid, 0);
    end else begin
      chk({tag, " R8 busy rises"}, busy, 1);
    end
    while (!done && cyc < 60) begin
      cyc_ready = (stall == 1) ? cyc[0] : (stall == 2) ? (cyc >= 3) : 1'b1;
      if (prev_stall) begin
        chk({tag, " R7 held valid"}, cyc_valid, 1);
        chk({tag, " R7 held byte"}, cyc_byte, pb);
        chk({tag, " R7 held tag"}, cyc_last, pl);
      end
      if (cyc_valid && cyc_ready) begin
        if (got < 8) begin gb[got] = cyc_byte; gl[got] = cyc_last; end
        got++;
      end
      prev_stall = cyc_valid && !cyc_ready;
      pb = cyc_byte; pl = cyc_last;
      if (poke && cyc == 1) begin
        start = 1; page_addr = ~addr; col_present = 1; page_present = 1;
      end
      @(negedge clk);
      start = 0;
      cyc++;
    end
    cyc_ready = 0;
    chk({tag, " R8 done seen"}, done, 1);
    chk({tag, " R8 busy low at done"}, busy, 0);
    chk({tag, " R1/R3/R4/R5 cycle count"}, got, n);
    for (int k = 0; k < n && k < got; k++) begin
      chk($sformatf("%s R2 byte %0d", tag, k), gb[k], eb[k]);
      chk($sformatf("%s R6 tag %0d", tag, k), gl[k], el[k]);
    end
    @(negedge clk);
    chk({tag, " R8 done is a pulse"}, done, 0);
    chk({tag, " R8 no second sequence"}, cyc_valid, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 busy", busy, 0);
    chk("R10 valid", cyc_valid, 0);
    chk("R10 done", done, 0);
    rst_n = 1;
    run_seq("small 32M",     1, 1, 24'h345612, 0, 25, 0, 0); // R4 two bytes
    run_seq("small 64M",     1, 1, 24'hA1B2C3, 0, 26, 0, 0); // R4 three bytes
    run_seq("big 128M",      1, 1, 24'h0F1E2D, 1, 27, 1, 0); // R1 R3
    run_seq("big 256M",      1, 1, 24'h778899, 1, 28, 2, 0); // R3 R7
    run_seq("page only",     0, 1, 24'h5A6B7C, 1, 30, 1, 0); // R2
    run_seq("col only small",1, 0, 24'hFFFFFF, 0, 30, 0, 0); // R5 R6
    run_seq("col only big",  1, 0, 24'hFFFFFF, 1, 30, 2, 0); // R6
    run_seq("empty",         0, 0, 24'h123456, 1, 30, 0, 0); // R9
    run_seq("poke busy",     1, 1, 24'h13579B, 1, 28, 1, 1); // R8
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule